// File: doc/BRIEF.md
# Dual-Lane Saturating Multiply-Accumulate

This unit works on two packed 32-bit lanes carried in 64-bit operands. In each lane it multiplies the A word by the B word and keeps only the low 32 bits of the product. It then adds that value to the matching word of a 64-bit accumulator register, or subtracts it from that word. A two-bit mode chooses between add and subtract, and between wrapping (modulo) and clamping (saturating) arithmetic. The new accumulator value is the result, and it is also kept for the next operation.

Each lane has an overflow flag that reflects its most recent saturating operation. Each lane also has a sticky flag that collects every overflow since reset. A separate load port writes the accumulator directly, for example to seed a dot product. A synchronous reset clears everything.

Top module: `dlmac_dual`

## Requirements
- R1: Each lane multiplies its 32-bit A and B words and uses only the low 32 bits of the product. Lane 0 occupies bits 31:0 of every 64-bit bus and lane 1 occupies bits 63:32. The two lanes are independent.
- R2: When mode bit 0 is 0, the product is added to the lane's accumulator word. When mode bit 0 is 1, the product is subtracted from it.
- R3: When mode bit 1 is 0 (modulo), the 32-bit sum or difference wraps around. The overflow and sticky flags keep their previous values.
- R4: When mode bit 1 is 1 (saturating), both terms are sign-extended to 33 bits before the add or subtract. The lane overflows when bit 32 of the result differs from bit 31. An overflowing lane takes 0x80000000 if bit 32 is 1 and 0x7FFFFFFF otherwise. A result that lands exactly on either limit is not an overflow.
- R5: After a saturating operation, `ovf_lane[i]` is 1 exactly when lane i overflowed in that operation (bit 1 is lane 1).
- R6: After a saturating operation, `ovf_sticky[i]` becomes its old value ORed with that operation's overflow for lane i. It only clears on reset.
- R7: An accepted operation updates `result` (the accumulator) at the next clock edge, and `res_valid` is 1 for exactly that one cycle. With no operation and no load, `result` holds its value.
- R8: Operations in consecutive cycles each use the accumulator value left by the previous one.
- R9: When `ld_en` is 1, the accumulator takes `ld_data` at the next edge and both flag sets are unchanged. An operation in the same cycle is dropped and produces no `res_valid`.
- R10: When `rst` is 1 at a clock edge, the accumulator, all flags and `res_valid` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| mode | input | 2 | Bit 0: subtract; bit 1: saturate |
| op_a | input | 64 | Packed A words |
| op_b | input | 64 | Packed B words |
| ld_en | input | 1 | Direct accumulator load |
| ld_data | input | 64 | Value for a direct load |
| res_valid | output | 1 | One-cycle pulse after an accepted operation |
| result | output | 64 | Accumulator contents |
| ovf_lane | output | 2 | Overflow of the latest saturating operation, per lane |
| ovf_sticky | output | 2 | Accumulated overflow per lane |

## Verification
The properties assume that `in_valid`, `ld_en` and `mode` have known values in every cycle after reset. They also assume reset is asserted at the first edge, so the sticky-flag and hold checks compare only against states the block itself produced. The bench keeps to these assumptions in three ways. It holds reset for several edges at start-up. It changes every input on the falling edge only. It returns `in_valid` and `ld_en` to 0 between directed steps, so each step's effect stands on its own when the outputs are read.

// File: rtl/dlmac_pkg.sv
package dlmac_pkg;
   // Operation mode as applied on the 2-bit mode port
   typedef struct packed {
      logic sat;   // bit 1: clamp on signed overflow
      logic sub;   // bit 0: subtract product from accumulator
   } mac_mode_t;

   function automatic logic [1:0] mode_bits(input mac_mode_t m);
      return {m.sat, m.sub};
   endfunction
endpackage

// File: rtl/dlmac_lane.sv
// One lane: truncated product and 33-bit signed add/subtract
module dlmac_lane #(
   parameter int LANE_W = 32
) (
   input  logic [LANE_W-1:0] acc_w,
   input  logic [LANE_W-1:0] a_w,
   input  logic [LANE_W-1:0] b_w,
   input  logic              do_sub,
   output logic [LANE_W:0]   wide_sum
);
   localparam int EXT_W = LANE_W + 1;

   logic [LANE_W-1:0] prod_lo;
   logic [EXT_W-1:0]  acc_ext;
   logic [EXT_W-1:0]  prod_ext;

   // assignment context is LANE_W wide, so only the low half is formed
   assign prod_lo  = a_w * b_w;
   assign acc_ext  = {acc_w[LANE_W-1], acc_w};
   assign prod_ext = {prod_lo[LANE_W-1], prod_lo};

   always_comb begin
      if (do_sub) wide_sum = acc_ext - prod_ext;
      else        wide_sum = acc_ext + prod_ext;
   end
endmodule

// File: rtl/dlmac_clamp.sv
// Overflow detection and clamp/wrap selection for one lane
module dlmac_clamp #(
   parameter int LANE_W = 32
) (
   input  logic [LANE_W:0]   wide_sum,
   input  logic              sat_en,
   output logic [LANE_W-1:0] lane_next,
   output logic              lane_ovf
);
   localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] NEG_LIM = {1'b1, {(LANE_W-1){1'b0}}};

   logic top_bit;
   logic sign_bit;

   assign top_bit  = wide_sum[LANE_W];
   assign sign_bit = wide_sum[LANE_W-1];
   assign lane_ovf = sat_en & (top_bit ^ sign_bit);

   always_comb begin
      if (lane_ovf) lane_next = top_bit ? NEG_LIM : POS_LIM;
      else          lane_next = wide_sum[LANE_W-1:0];
   end
endmodule

// File: rtl/dlmac_dual.sv
module dlmac_dual
   import dlmac_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 32,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_data,
   output logic              res_valid,
   output logic [DATA_W-1:0] result,
   output logic [LANES-1:0]  ovf_lane,
   output logic [LANES-1:0]  ovf_sticky
);
   // elaboration-time parameter checks
   generate
      if (LANE_W < 2) begin : g_bad_width
         $error("dlmac_dual: LANE_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("dlmac_dual: LANES must be at least 1");
      end
   endgenerate

   mac_mode_t         md;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] acc_next;
   logic [LANES-1:0]  ovf_next;
   logic [LANES-1:0]  ovf_q;
   logic [LANES-1:0]  sticky_q;
   logic              vld_q;
   logic              op_take;

   assign md      = mac_mode_t'(mode);
   assign op_take = in_valid & ~ld_en;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W:0] sum_w;

         dlmac_lane #(.LANE_W(LANE_W)) u_lane (
            .acc_w    (acc_q[g*LANE_W +: LANE_W]),
            .a_w      (op_a[g*LANE_W +: LANE_W]),
            .b_w      (op_b[g*LANE_W +: LANE_W]),
            .do_sub   (md.sub),
            .wide_sum (sum_w)
         );

         dlmac_clamp #(.LANE_W(LANE_W)) u_clamp (
            .wide_sum  (sum_w),
            .sat_en    (md.sat),
            .lane_next (acc_next[g*LANE_W +: LANE_W]),
            .lane_ovf  (ovf_next[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q    <= '0;
         ovf_q    <= '0;
         sticky_q <= '0;
         vld_q    <= 1'b0;
      end else begin
         vld_q <= op_take;
         if (ld_en) begin
            acc_q <= ld_data;
         end else if (in_valid) begin
            acc_q <= acc_next;
            if (md.sat) begin
               ovf_q    <= ovf_next;
               sticky_q <= sticky_q | ovf_next;
            end
         end
      end
   end

   assign result     = acc_q;
   assign res_valid  = vld_q;
   assign ovf_lane   = ovf_q;
   assign ovf_sticky = sticky_q;
endmodule

// File: rtl/dlmac_dual_chk.sv
module dlmac_dual_chk #(
   parameter int LANES  = 2,
   parameter int LANE_W = 32,
   localparam int DATA_W = LANES * LANE_W
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [1:0]        mode,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic              ld_en,
   input logic [DATA_W-1:0] ld_data,
   input logic              res_valid,
   input logic [DATA_W-1:0] result,
   input logic [LANES-1:0]  ovf_lane,
   input logic [LANES-1:0]  ovf_sticky
);
   localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] NEG_LIM = {1'b1, {(LANE_W-1){1'b0}}};

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (result == '0 && ovf_lane == '0 && ovf_sticky == '0 && !res_valid));

   p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
      ld_en |=> (result == $past(ld_data) && !res_valid &&
                 ovf_lane == $past(ovf_lane) && ovf_sticky == $past(ovf_sticky)));

   p_latency_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ld_en) |=> res_valid);

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !ld_en) |=> (!res_valid && $stable(result)));

   p_modulo_flags_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ld_en && !mode[1]) |=> ($stable(ovf_lane) && $stable(ovf_sticky)));

   p_sticky_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (ovf_sticky != '0) |=> ((ovf_sticky & $past(ovf_sticky)) == $past(ovf_sticky)));

   p_sticky_covers_r6: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> ((ovf_lane & ~ovf_sticky) == '0));

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
         p_sat_value_r4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !ld_en && mode[1]) |=>
               (!ovf_lane[g] || result[g*LANE_W +: LANE_W] == POS_LIM ||
                result[g*LANE_W +: LANE_W] == NEG_LIM));
      end
   endgenerate
endmodule

bind dlmac_dual dlmac_dual_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/dlmac_dual_bench.sv
module dlmac_dual_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        ld_en = 1'b0;
   logic [63:0] ld_data = '0;
   logic        res_valid;
   logic [63:0] result;
   logic [1:0]  ovf_lane;
   logic [1:0]  ovf_sticky;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   dlmac_dual u_dlmac_dual (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
      .op_a(op_a), .op_b(op_b), .ld_en(ld_en), .ld_data(ld_data),
      .res_valid(res_valid), .result(result),
      .ovf_lane(ovf_lane), .ovf_sticky(ovf_sticky)
   );

   typedef struct packed {
      logic [1:0]  md;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] exp_res;
      logic [1:0]  exp_ovf;
      logic [1:0]  exp_stk;
   } vec_t;

   // applied in order starting from a cleared accumulator
   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{2'b00, {32'd3, 32'd5}, {32'd7, 32'd2}, {32'd21, 32'd10}, 2'b00, 2'b00},
      '{2'b01, {32'd2, 32'd4}, {32'd5, 32'd1}, {32'd11, 32'd6}, 2'b00, 2'b00},
      '{2'b00, 64'h00010000_FFFFFFFF, 64'h00010003_00000002, 64'h0003000B_00000004, 2'b00, 2'b00},
      '{2'b10, 64'h7FFFFFFF_00000001, 64'h00000001_00000003, 64'h7FFFFFFF_00000007, 2'b10, 2'b10},
      '{2'b11, 64'h00000001_80000000, 64'h00000001_00000001, 64'h7FFFFFFE_7FFFFFFF, 2'b01, 2'b11},
      '{2'b10, 64'h0, 64'h0, 64'h7FFFFFFE_7FFFFFFF, 2'b00, 2'b11},
      '{2'b00, 64'h00000002_00000000, 64'h00000001_00000000, 64'h80000000_7FFFFFFF, 2'b00, 2'b11},
      '{2'b10, 64'hFFFFFFFF_00000000, 64'h00000001_00000000, 64'h80000000_7FFFFFFF, 2'b10, 2'b11},
      '{2'b01, 64'h00000001_00000001, 64'h00000001_00000001, 64'h7FFFFFFF_7FFFFFFE, 2'b10, 2'b11}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // one operation: drive at a falling edge, read at the next falling edge
   task automatic do_op(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      mode = m; op_a = a; op_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      // R10: state after reset
      chk("R10 result", result, 64'h0);
      chk("R10 flags", {60'h0, ovf_lane, ovf_sticky}, 64'h0);
      chk("R10 res_valid", {63'h0, res_valid}, 64'h0);

      // table walk: R1 R2 R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         do_op(VECS[i].md, VECS[i].a, VECS[i].b);
         chk($sformatf("R1/R2/R3/R4 vector %0d result", i), result, VECS[i].exp_res);
         chk($sformatf("R5 vector %0d ovf_lane", i), {62'h0, ovf_lane}, {62'h0, VECS[i].exp_ovf});
         chk($sformatf("R6 vector %0d ovf_sticky", i), {62'h0, ovf_sticky}, {62'h0, VECS[i].exp_stk});
      end

      // R10: reset after activity
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R10 result after activity", result, 64'h0);
      chk("R10 flags after activity", {60'h0, ovf_lane, ovf_sticky}, 64'h0);

      // R7: one-cycle latency and single pulse
      do_op(2'b00, {32'd1, 32'd1}, {32'd4, 32'd9});
      chk("R7 res_valid pulse", {63'h0, res_valid}, 64'h1);
      chk("R7 result", result, {32'd4, 32'd9});
      @(negedge clk);
      chk("R7 res_valid drops", {63'h0, res_valid}, 64'h0);
      chk("R7 result holds", result, {32'd4, 32'd9});

      // R4/R5: positive overflow in lane 1 only
      do_op(2'b10, 64'h7FFFFFFF_00000000, 64'h00000001_00000000);
      chk("R4 positive clamp", result, 64'h7FFFFFFF_00000009);
      chk("R5 lane flags", {62'h0, ovf_lane}, 64'h2);

      // R9: load beats a simultaneous operation, flags kept
      @(negedge clk);
      ld_en = 1'b1; ld_data = 64'h12345678_9ABCDEF0;
      in_valid = 1'b1; mode = 2'b00; op_a = {32'd1, 32'd1}; op_b = {32'd1, 32'd1};
      @(negedge clk);
      ld_en = 1'b0; in_valid = 1'b0;
      chk("R9 load value", result, 64'h12345678_9ABCDEF0);
      chk("R9 no res_valid", {63'h0, res_valid}, 64'h0);
      chk("R9 flags kept", {60'h0, ovf_lane, ovf_sticky}, 64'hA);

      // seed near the limits for boundary tests
      @(negedge clk);
      ld_en = 1'b1; ld_data = 64'h7FFFFFFE_80000001;
      @(negedge clk);
      ld_en = 1'b0;

      // R8: back-to-back operations, R4 exact limits are not overflow
      mode = 2'b10; op_a = 64'h00000001_00000000; op_b = 64'h00000001_00000000; in_valid = 1'b1;
      @(negedge clk);
      chk("R8 first result", result, 64'h7FFFFFFF_80000001);
      chk("R4 exact upper limit no overflow", {62'h0, ovf_lane}, 64'h0);
      mode = 2'b11; op_a = 64'h00000000_00000001; op_b = 64'h00000000_00000001;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 second result", result, 64'h7FFFFFFF_80000000);
      chk("R8 res_valid on second", {63'h0, res_valid}, 64'h1);
      chk("R4 exact lower limit no overflow", {62'h0, ovf_lane}, 64'h0);

      // R4/R5/R6: negative overflow in lane 0
      do_op(2'b11, 64'h00000000_00000001, 64'h00000000_00000001);
      chk("R4 negative clamp", result, 64'h7FFFFFFF_80000000);
      chk("R5 lane 0 flag", {62'h0, ovf_lane}, 64'h1);
      chk("R6 sticky ORed", {62'h0, ovf_sticky}, 64'h3);

      @(negedge clk);
      finish_run();
   end
endmodule